// File: doc/BRIEF.md
# Mode-Pattern Extraction Permit Evaluator

This block decides whether beam may be extracted. Eleven condition inputs arrive as steady levels, and none of them can be masked. Each of five operating modes defines a pattern over these inputs. A pattern names some inputs that must be 1 and some that must be 0, and leaves the remaining inputs free. A mode matches when every input it cares about holds the value it requires. The permit is granted when at least one mode matches.

The pattern set is fixed in logic and cannot be changed at run time. The block also reports which mode matched, as a five-bit vector. It registers that vector and the permit on the same clock edge, so a consumer never sees a permit that disagrees with the reported match. In a given mode, the inputs it leaves free have no effect. This lets the early setup modes run while the downstream conditions are still unmet.

Top module: `xpermit_eval`

## Requirements
- R1: While `rst` is high at a rising clock edge, `mode_hit` and `permit` become 0 at that edge.
- R2: `mode_hit[0]` (mode 1) is 1 exactly when inputs 0, 1 and 2 are all 1. Inputs 3 to 10 are ignored.
- R3: `mode_hit[1]` (mode 2) is 1 exactly when inputs 0, 1, 3, 4 and 5 are 1 and input 2 is 0. Inputs 6 to 10 are ignored.
- R4: `mode_hit[2]` (mode 3) is 1 exactly when inputs 0, 1, 3, 4, 6, 7 and 10 are 1 and inputs 2 and 5 are 0. Inputs 8 and 9 are ignored.
- R5: `mode_hit[3]` (mode 4) is 1 exactly when inputs 0, 1, 3, 4, 6, 8 and 10 are 1 and inputs 2, 5 and 7 are 0. Input 9 is ignored.
- R6: `mode_hit[4]` (mode 5) is 1 exactly when inputs 0, 1, 3, 4, 6 and 8 are 1 and inputs 2, 5, 7, 9 and 10 are 0.
- R7: `permit` is 1 exactly when at least one bit of `mode_hit` is 1.
- R8: The outputs are registered. Both `mode_hit` and `permit` reflect the `cond_in` value sampled at the previous rising edge, and they do not change between edges.
- R9: Changing an input that a matching mode ignores leaves that mode's match bit at 1.
- R10: At most one bit of `mode_hit` is 1 at any time, because every pair of modes disagrees on at least one cared input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_in | input | 11 | Condition inputs; bit i is input i |
| mode_hit | output | 5 | Registered match vector; bit k is mode k+1 |
| permit | output | 1 | Registered extraction permit |

## Verification
Random input vectors almost never satisfy modes 3 to 5, because each of those modes fixes nine or more of the eleven inputs. The stimulus therefore picks a target mode, forces that mode's cared bits, and randomizes only the rest. This drives the free bits and the neighbouring modes' deciding bits, such as inputs 7 and 10, across their values. Directed sweeps then run every combination of the ignored inputs while a mode is held matched. Occasional resets in mid-run check that clearing takes precedence over a live match.

// File: rtl/xpermit_pkg.sv
package xpermit_pkg;

  localparam int unsigned COND_W  = 11;
  localparam int unsigned MODE_N  = 5;

  typedef struct packed {
    logic              live;
    logic [COND_W-1:0] want;
    logic [COND_W-1:0] care;
  } mode_pat_t;

  // Pattern set; bit i of want/care is condition input i.
  function automatic mode_pat_t mode_pattern(input int unsigned idx);
    mode_pat_t p;
    p = '{live: 1'b0, want: '0, care: '0};
    case (idx)
      0: p = '{live: 1'b1, want: 11'b000_0000_0111, care: 11'b000_0000_0111};
      1: p = '{live: 1'b1, want: 11'b000_0011_1011, care: 11'b000_0011_1111};
      2: p = '{live: 1'b1, want: 11'b100_1101_1011, care: 11'b100_1111_1111};
      3: p = '{live: 1'b1, want: 11'b101_0101_1011, care: 11'b101_1111_1111};
      4: p = '{live: 1'b1, want: 11'b001_0101_1011, care: 11'b111_1111_1111};
      default: p = '{live: 1'b0, want: '0, care: '0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/xpermit_pattern_rom.sv
module xpermit_pattern_rom
  import xpermit_pkg::*;
#(
  parameter int unsigned N_MODE = MODE_N
) (
  output mode_pat_t [N_MODE-1:0] pats
);
  for (genvar k = 0; k < N_MODE; k++) begin : g_pat
    assign pats[k] = mode_pattern(k);
  end
endmodule

// File: rtl/xpermit_mode_match.sv
module xpermit_mode_match
  import xpermit_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  mode_pat_t         pat,
  output logic              hit
);
  logic [COND_W-1:0] miss;

  always_comb begin
    miss = (cond ^ pat.want) & pat.care;
    hit  = pat.live && (miss == '0);
  end
endmodule

// File: rtl/xpermit_out_reg.sv
module xpermit_out_reg #(
  parameter int unsigned N_MODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MODE-1:0] hit_d,
  output logic [N_MODE-1:0] hit_q,
  output logic              permit_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q    <= '0;
      permit_q <= 1'b0;
    end else begin
      hit_q    <= hit_d;
      permit_q <= |hit_d;
    end
  end
endmodule

// File: rtl/xpermit_eval.sv
module xpermit_eval
  import xpermit_pkg::*;
#(
  parameter int unsigned N_MODE = MODE_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_in,
  output logic [N_MODE-1:0] mode_hit,
  output logic              permit
);
  mode_pat_t [N_MODE-1:0] pats;
  logic      [N_MODE-1:0] hit_c;

  xpermit_pattern_rom #(.N_MODE(N_MODE)) u_rom (.pats(pats));

  for (genvar k = 0; k < N_MODE; k++) begin : g_match
    xpermit_mode_match u_match (
      .cond (cond_in),
      .pat  (pats[k]),
      .hit  (hit_c[k])
    );
  end

  xpermit_out_reg #(.N_MODE(N_MODE)) u_oreg (
    .clk      (clk),
    .rst      (rst),
    .hit_d    (hit_c),
    .hit_q    (mode_hit),
    .permit_q (permit)
  );
endmodule

// File: rtl/xpermit_eval_chk.sv
module xpermit_eval_chk (
  input logic        clk,
  input logic        rst,
  input logic [10:0] cond_in,
  input logic [4:0]  mode_hit,
  input logic        permit
);
  AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mode_hit)); // R10
  AST_PERMIT_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (rst)
    permit == (mode_hit != 5'd0)); // R7
  AST_MODE1_SET: assert property (@(posedge clk) disable iff (rst)
    (cond_in[2:0] == 3'b111) |=> mode_hit[0]); // R2
  AST_MODE1_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cond_in[2:0] != 3'b111) |=> !mode_hit[0]); // R2
  AST_MODE5_EXACT: assert property (@(posedge clk) disable iff (rst)
    (cond_in == 11'b001_0101_1011) |=> (mode_hit == 5'b10000)); // R6
  AST_INPUT0_GATES: assert property (@(posedge clk) disable iff (rst)
    !cond_in[0] |=> !permit); // R7
  AST_INPUT2_SPLITS: assert property (@(posedge clk) disable iff (rst)
    cond_in[2] |=> (mode_hit[4:1] == 4'd0)); // R3
endmodule

bind xpermit_eval xpermit_eval_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cond_in  (cond_in),
  .mode_hit (mode_hit),
  .permit   (permit)
);

// File: tb/xpermit_eval_bench.sv
module xpermit_eval_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] cond_in = '0;
  logic [4:0]  mode_hit;
  logic        permit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { bit r; logic [10:0] x; } stim_t;
  stim_t pend[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpermit_eval u_xpermit_eval (
    .clk(clk), .rst(rst), .cond_in(cond_in), .mode_hit(mode_hit), .permit(permit)
  );

  // Behavioural model written from the requirements.
  function automatic logic [4:0] model(input logic [10:0] x);
    logic common;
    logic [4:0] m;
    common = x[0] & x[1] & !x[2] & x[3] & x[4];
    m[0] = x[0] & x[1] & x[2];
    m[1] = common & x[5];
    m[2] = common & !x[5] & x[6] & x[7] & x[10];
    m[3] = common & !x[5] & x[6] & !x[7] & x[8] & x[10];
    m[4] = common & !x[5] & x[6] & !x[7] & x[8] & !x[9] & !x[10];
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input logic [10:0] x);
    stim_t s;
    logic [4:0] exp_hit;
    logic [4:0] held_hit;
    logic held_p;
    @(negedge clk);
    if (pend.size() > 0) begin
      s = pend.pop_front();
      exp_hit = s.r ? 5'd0 : model(s.x);
      if (s.r) chk(mode_hit == 5'd0 && permit == 1'b0, "R1", {mode_hit, permit}, 0);
      chk(mode_hit[0] == exp_hit[0], "R2", mode_hit, exp_hit);
      chk(mode_hit[1] == exp_hit[1], "R3", mode_hit, exp_hit);
      chk(mode_hit[2] == exp_hit[2], "R4", mode_hit, exp_hit);
      chk(mode_hit[3] == exp_hit[3], "R5", mode_hit, exp_hit);
      chk(mode_hit[4] == exp_hit[4], "R6", mode_hit, exp_hit);
      chk(permit == (exp_hit != 0), "R7", permit, exp_hit != 0);
      chk($countones(mode_hit) <= 1, "R10", mode_hit, exp_hit);
    end
    held_hit = mode_hit;
    held_p   = permit;
    rst     = r;
    cond_in = x;
    s.r = r; s.x = x;
    pend.push_back(s);
    #1;
    chk(mode_hit == held_hit && permit == held_p, "R8", {mode_hit, permit}, {held_hit, held_p});
  endtask

  // Force one mode's cared bits, leave the rest random.
  function automatic logic [10:0] aim(input int m, input logic [10:0] rnd);
    logic [10:0] x;
    x = rnd;
    if (m == 0) begin x[0] = 1; x[1] = 1; x[2] = 1; end
    if (m >= 1 && m <= 4) begin
      x[0] = 1; x[1] = 1; x[2] = 0; x[3] = 1; x[4] = 1;
    end
    if (m == 1) x[5] = 1;
    if (m >= 2 && m <= 4) begin x[5] = 0; x[6] = 1; end
    if (m == 2) begin x[7] = 1; x[10] = 1; end
    if (m == 3) begin x[7] = 0; x[8] = 1; x[10] = 1; end
    if (m == 4) begin x[7] = 0; x[8] = 1; x[9] = 0; x[10] = 0; end
    return x;
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    // R1: reset held while a mode-1 pattern is present
    step(1'b1, 11'b000_0000_0111);
    step(1'b1, 11'b000_0000_0111);
    step(1'b0, 11'd0);
    // exact base patterns for every mode
    step(1'b0, 11'b000_0000_0111);
    step(1'b0, 11'b000_0011_1011);
    step(1'b0, 11'b100_1101_1011);
    step(1'b0, 11'b101_0101_1011);
    step(1'b0, 11'b001_0101_1011);
    step(1'b0, 11'b111_1111_1111);
    step(1'b0, 11'd0);
    // R9: sweep the ignored inputs while a mode stays matched
    for (int v = 0; v < 256; v++) step(1'b0, {v[7:0], 3'b111});
    for (int v = 0; v < 32; v++)  step(1'b0, {v[4:0], 6'b11_1011});
    for (int v = 0; v < 4; v++)   step(1'b0, {1'b1, v[1:0], 8'b1101_1011});
    for (int v = 0; v < 2; v++)   step(1'b0, {1'b1, v[0], 9'b1_0101_1011});
    // R1: reset in mid-run over a live match
    step(1'b0, 11'b001_0101_1011);
    step(1'b1, 11'b001_0101_1011);
    step(1'b0, 11'b001_0101_1011);
    // biased random
    for (int i = 0; i < 4000; i++) begin
      int m;
      logic [10:0] rnd;
      m = $urandom_range(0, 6);
      rnd = 11'($urandom);
      step(($urandom_range(0, 99) == 0), aim(m, rnd));
    end
    step(1'b0, 11'd0);
    step(1'b0, 11'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule